// File: doc/BRIEF.md
# Byte-Wide EPROM Read Sequencer

This block lets synchronous logic read an asynchronous, byte-wide, UV-erasable read-only memory of 524,288 locations. A host presents a 19-bit location on a one-cycle request strobe. The sequencer latches that location and drives it onto the memory address pins. It then lowers the active-low chip select. After a computed delay it lowers the active-low read strobe. It waits out the access time, samples the 8-bit data bus, and returns the byte together with a one-cycle acknowledge.

All waits are whole clock counts. They are derived at elaboration from a clock-period parameter and a speed-grade parameter. Grades 0 to 3 stand for full-access times of 120, 150, 170 and 200 ns. Each wait is the delay divided by the period, rounded up, plus one cycle of margin. Rounding up is always safe because a faster-rated memory also meets slower timing. After each read both strobes stay high for the release time of the memory's output drivers. Only then may another access begin or another agent take the data bus. A request that arrives while the block is busy is held in a single waiting slot and served afterwards.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: During and immediately after reset, `mem_ce_n` and `mem_oe_n` are 1, `host_ack` is 0 and `bus_free` is 1.
- R2: The address is taken from `host_addr` in the cycle `host_req` is accepted. It appears on `mem_addr` with the chip select and does not change while `mem_ce_n` is low. It keeps that value until the next access starts.
- R3: Each access holds `mem_ce_n` low for exactly ACC cycles. ACC = ceil(t_acc / CLK_NS) + 1, where t_acc is 120, 150, 170 or 200 ns for GRADE 0, 1, 2 or 3 (ACC = 7 at 20 ns, grade 0).
- R4: `mem_oe_n` is low only while `mem_ce_n` is low. It falls OE cycles before the chip select is released and stays low to the end of the access. OE = ceil(50 / CLK_NS) + 1 (OE = 4 at 20 ns). If OE is not smaller than ACC, it falls together with the chip select.
- R5: After an access, both strobes stay high for at least FLT + 1 cycles before `mem_ce_n` falls again. FLT = ceil(t_flt / CLK_NS) + 1, where t_flt is 35, 35, 45 or 55 ns by grade (FLT = 3 at 20 ns, grade 0).
- R6: `bus_free` goes low when a request is accepted. It returns high exactly FLT cycles after the cycle in which `host_ack` is high. While `bus_free` is high, both strobes are high.
- R7: `host_ack` is high for one cycle, in the cycle right after the last chip-select-low cycle. At that time `host_rdata` holds the byte on `mem_data` in that last cycle.
- R8: A request that arrives while an access or release wait is in progress is kept and not dropped. It is served after the release wait, in arrival order. Its acknowledge follows the previous one by FLT + 1 + ACC cycles. At most one request may wait at a time.
- R9: A request seen while the block is free starts the access on the next clock edge. Its acknowledge is seen ACC + 1 cycles after the request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | One-cycle read request strobe |
| host_addr | input | 19 | Location to read, valid with host_req |
| host_ack | output | 1 | One-cycle completion strobe |
| host_rdata | output | 8 | Byte read, valid with host_ack |
| bus_free | output | 1 | Data bus released and no access in progress |
| mem_addr | output | 19 | Memory address pins |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_data | input | 8 | Memory data bus |

## Verification
If the wait counter or state register goes wrong, the strobe widths change. That shows on the ports within one access: a chip-select pulse of the wrong length, a read strobe that starts at the wrong cycle, or too short a gap before the next select. The bench's memory model also returns the inverted byte whenever the select time, the read-strobe time or the address stable time falls short. A timing error therefore also shows as wrong data on the very next acknowledge. A lost or reordered waiting request shows as a missing acknowledge or a byte for the wrong address. An acknowledge spacing other than FLT + 1 + ACC shows within one access time.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    localparam int ADDR_W    = 19;
    localparam int DATA_W    = 8;
    localparam int OE_ACC_NS = 50;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FLOAT  = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } rd_req_t;

    // Full access time (address or chip select to data) per speed grade.
    function automatic int grade_acc_ns(input int grade);
        case (grade)
            0:       return 120;
            1:       return 150;
            2:       return 170;
            default: return 200;
        endcase
    endfunction

    // Output release time per speed grade.
    function automatic int grade_flt_ns(input int grade);
        case (grade)
            0, 1:    return 35;
            2:       return 45;
            default: return 55;
        endcase
    endfunction

    // Round up to whole clocks, then add one cycle of margin.
    function automatic int ns_to_cycles(input int ns, input int period);
        return (ns + period - 1) / period + 1;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_dn_cnt.sv
module eprom_dn_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == W'(1));
endmodule

// File: rtl/eprom_req_slot.sv
module eprom_req_slot
    import eprom_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              take,
    output rd_req_t           nxt
);
    rd_req_t held;
    rd_req_t incoming;

    assign incoming = '{vld: in_vld, addr: in_addr};
    // The held request is older, so it is offered first.
    assign nxt = held.vld ? held : incoming;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (take) begin
            // Served the held one: the new arrival, if any, waits in its place.
            held <= held.vld ? incoming : '0;
        end else if (in_vld) begin
            held <= incoming;
        end
    end
endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int ACC_CYC = 7,
    parameter int OE_CYC  = 4,
    parameter int FLT_CYC = 3,
    parameter int CNT_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_req_t           nxt,
    output logic              take,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cnt_last,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              cnt_dec,
    input  logic [DATA_W-1:0] mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_free
);
    localparam bit OE_EARLY = (OE_CYC >= ACC_CYC);
    localparam int OE_MARK  = OE_EARLY ? 0 : OE_CYC + 1;

    rd_state_e state;

    assign take     = (state == ST_IDLE) && nxt.vld;
    assign cnt_load = take || ((state == ST_ACCESS) && cnt_last);
    assign cnt_val  = take ? CNT_W'(ACC_CYC) : CNT_W'(FLT_CYC);
    assign cnt_dec  = (state != ST_IDLE) && !cnt_last;
    assign bus_free = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            mem_addr <= '0;
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            ack      <= 1'b0;
            rdata    <= '0;
        end else begin
            ack <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        mem_addr <= nxt.addr;
                        mem_ce_n <= 1'b0;
                        mem_oe_n <= !OE_EARLY;
                        state    <= ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (cnt_last) begin
                        rdata    <= mem_data;
                        ack      <= 1'b1;
                        mem_ce_n <= 1'b1;
                        mem_oe_n <= 1'b1;
                        state    <= ST_FLOAT;
                    end else if (!OE_EARLY && cnt == CNT_W'(OE_MARK)) begin
                        mem_oe_n <= 1'b0;
                    end
                end
                ST_FLOAT: begin
                    if (cnt_last) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int CLK_NS = 20,
    parameter int GRADE  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic              bus_free,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_data
);
    localparam int ACC_CYC = ns_to_cycles(grade_acc_ns(GRADE), CLK_NS);
    localparam int OE_CYC  = ns_to_cycles(OE_ACC_NS, CLK_NS);
    localparam int FLT_CYC = ns_to_cycles(grade_flt_ns(GRADE), CLK_NS);
    localparam int CNT_MAX = max2(ACC_CYC, FLT_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    rd_req_t            nxt;
    logic               take;
    logic [CNT_W-1:0]   cnt;
    logic               cnt_last;
    logic               cnt_load;
    logic [CNT_W-1:0]   cnt_val;
    logic               cnt_dec;

    eprom_req_slot u_slot (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (host_req),
        .in_addr (host_addr),
        .take    (take),
        .nxt     (nxt)
    );

    eprom_dn_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .cnt      (cnt),
        .last     (cnt_last)
    );

    eprom_rd_seq #(
        .ACC_CYC (ACC_CYC),
        .OE_CYC  (OE_CYC),
        .FLT_CYC (FLT_CYC),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .nxt      (nxt),
        .take     (take),
        .cnt      (cnt),
        .cnt_last (cnt_last),
        .cnt_load (cnt_load),
        .cnt_val  (cnt_val),
        .cnt_dec  (cnt_dec),
        .mem_data (mem_data),
        .mem_addr (mem_addr),
        .mem_ce_n (mem_ce_n),
        .mem_oe_n (mem_oe_n),
        .ack      (host_ack),
        .rdata    (host_rdata),
        .bus_free (bus_free)
    );
endmodule

// File: rtl/eprom_rd_chk.sv
module eprom_rd_chk #(
    parameter int ACC_CYC = 7,
    parameter int OE_CYC  = 4,
    parameter int FLT_CYC = 3,
    parameter int ADDR_W  = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ack,
    input logic              bus_free
);
    localparam int OE_EXP = (OE_CYC >= ACC_CYC) ? ACC_CYC : OE_CYC;

    logic [7:0] lo_cnt;
    logic [7:0] oe_cnt;
    logic [7:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
            oe_cnt <= '0;
            hi_cnt <= 8'hFF;
        end else begin
            lo_cnt <= !ce_n ? ((lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 8'd1) : 8'd0;
            oe_cnt <= !oe_n ? ((oe_cnt == 8'hFF) ? oe_cnt : oe_cnt + 8'd1) : 8'd0;
            hi_cnt <=  ce_n ? ((hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1) : 8'd0;
        end
    end

    p_ce_width_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ce_n) |-> (lo_cnt == 8'(ACC_CYC)));

    p_oe_inside_ce_r4: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> !ce_n);

    p_oe_width_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_n) |-> (oe_cnt == 8'(OE_EXP)));

    p_gap_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(ce_n) |-> (hi_cnt >= 8'(FLT_CYC + 1)));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && $past(!ce_n)) |-> $stable(addr));

    p_free_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        bus_free |-> (ce_n && oe_n));

    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    p_ack_end_r7: assert property (@(posedge clk) disable iff (rst)
        ack |-> $rose(ce_n));

    p_ack_busy_r6: assert property (@(posedge clk) disable iff (rst)
        ack |-> !bus_free);
endmodule

bind eprom_rd_ctrl eprom_rd_chk #(
    .ACC_CYC (ACC_CYC),
    .OE_CYC  (OE_CYC),
    .FLT_CYC (FLT_CYC),
    .ADDR_W  (eprom_rd_pkg::ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (mem_ce_n),
    .oe_n     (mem_oe_n),
    .addr     (mem_addr),
    .ack      (host_ack),
    .bus_free (bus_free)
);

// File: tb/sim_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module sim_eprom_rd_ctrl;
    localparam int PER   = 20;
    localparam int ACC_E = (120 + PER - 1) / PER + 1;  // 7
    localparam int OE_E  = (50 + PER - 1) / PER + 1;   // 4
    localparam int FLT_E = (35 + PER - 1) / PER + 1;   // 3

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic [18:0] host_addr = '0;
    logic        host_ack;
    logic [7:0]  host_rdata;
    logic        bus_free;
    logic [18:0] mem_addr;
    logic        mem_ce_n;
    logic        mem_oe_n;
    logic [7:0]  mem_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    eprom_rd_ctrl #(.CLK_NS(PER), .GRADE(0)) u0 (
        .clk(clk), .rst(rst), .host_req(host_req), .host_addr(host_addr),
        .host_ack(host_ack), .host_rdata(host_rdata), .bus_free(bus_free),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_data(mem_data)
    );

    function automatic logic [7:0] rom_val(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model: correct byte only when select, read strobe and address
    // have all been in place long enough; otherwise the inverted byte.
    int          m_ce = 0, m_oe = 0, m_ad = 0;
    logic [18:0] m_prev = '0;
    logic        m_ok;
    assign m_ok     = (m_ce >= ACC_E) && (m_oe >= OE_E) && (m_ad >= ACC_E);
    assign mem_data = m_ok ? rom_val(mem_addr) : ~rom_val(mem_addr);

    // Strobe monitor.
    logic p_ce = 1'b1, p_oe = 1'b1;
    int   w_ce = 0, w_oe = 0, g_ce = 1000;

    always @(negedge clk) begin
        m_ce   <= !mem_ce_n ? m_ce + 1 : 0;
        m_oe   <= !mem_oe_n ? m_oe + 1 : 0;
        m_ad   <= (mem_addr != m_prev) ? 1 : m_ad + 1;
        m_prev <= mem_addr;
        if (!rst) begin
            if (!mem_oe_n && mem_ce_n) chk(1'b0, "R4 oe outside ce", 1, 0);
            if (mem_ce_n && !p_ce) chk(w_ce == ACC_E, "R3 ce low width", w_ce, ACC_E);
            if (mem_oe_n && !p_oe) chk(w_oe == OE_E, "R4 oe low width", w_oe, OE_E);
            if (!mem_ce_n && p_ce) chk(g_ce >= FLT_E + 1, "R5 release gap", g_ce, FLT_E + 1);
            if (bus_free && !(mem_ce_n && mem_oe_n)) chk(1'b0, "R6 strobes while free", 0, 1);
            w_ce = !mem_ce_n ? w_ce + 1 : 0;
            w_oe = !mem_oe_n ? w_oe + 1 : 0;
            g_ce = mem_ce_n ? g_ce + 1 : 0;
            p_ce = mem_ce_n;
            p_oe = mem_oe_n;
        end
    end

    task automatic single_read(input logic [18:0] a);
        int lat;
        @(posedge clk); #1;
        host_req = 1'b1; host_addr = a;
        @(posedge clk); #1;
        host_req = 1'b0; host_addr = ~a;
        lat = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            lat++;
            if (host_ack) break;
        end
        chk(host_ack, "R9 ack seen", host_ack, 1);
        chk(lat == ACC_E + 1, "R9 latency", lat, ACC_E + 1);
        chk(host_rdata == rom_val(a), "R7 data", host_rdata, rom_val(a));
        chk(mem_addr == a, "R2 address", mem_addr, a);
        chk(!bus_free, "R6 busy at ack", bus_free, 0);
        @(negedge clk);
        chk(!host_ack, "R7 single pulse", host_ack, 0);
        repeat (FLT_E - 2) @(negedge clk);
        chk(!bus_free, "R6 still releasing", bus_free, 0);
        @(negedge clk);
        chk(bus_free, "R6 free after release", bus_free, 1);
    endtask

    task automatic pair_read(input logic [18:0] a, input logic [18:0] b, input int dly);
        int t = 0, t1 = -1, t2 = -1;
        logic [7:0] d1 = '0, d2 = '0;
        @(posedge clk); #1;
        host_req = 1'b1; host_addr = a;
        @(posedge clk); #1;
        host_req = 1'b0;
        repeat (dly) @(posedge clk);
        #1;
        host_req = 1'b1; host_addr = b;
        @(posedge clk); #1;
        host_req = 1'b0; host_addr = '0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            t++;
            if (host_ack && t1 < 0) begin t1 = t; d1 = host_rdata; end
            else if (host_ack) begin t2 = t; d2 = host_rdata; break; end
        end
        chk(t2 >= 0, "R8 second ack present", t2, 1);
        chk(d1 == rom_val(a), "R8 first data", d1, rom_val(a));
        chk(d2 == rom_val(b), "R8 queued data", d2, rom_val(b));
        chk(t2 - t1 == FLT_E + 1 + ACC_E, "R8 ack spacing", t2 - t1, FLT_E + 1 + ACC_E);
        repeat (FLT_E + 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n, "R1 strobes in reset", {mem_ce_n, mem_oe_n}, 3);
        chk(!host_ack && bus_free, "R1 ack/free in reset", {host_ack, bus_free}, 1);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && !host_ack && bus_free, "R1 after reset",
            {mem_ce_n, mem_oe_n, host_ack, bus_free}, 4'b1101);
        single_read(19'h00000);
        single_read(19'h7FFFF);
        for (int i = 0; i < 19; i++) single_read(19'(1) << i);
        for (int i = 0; i < 40; i++) single_read(19'((i * 12347 + 5) & 19'h7FFFF));
        pair_read(19'h12345, 19'h54321, 0);
        pair_read(19'h00F0F, 19'h7F0F0, 2);
        pair_read(19'h40001, 19'h3FFFE, 5);
        for (int i = 0; i < 6; i++) pair_read(19'(i * 4099), 19'(~(i * 4099)), i);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule